// File: doc/BRIEF.md
# Transaction Dependency Vector Tracker

This block is the per-processor dependency controller of a transactional memory extension that lets transactions read one another's uncommitted data instead of aborting at the first conflict. It holds four bit vectors: predecessors (processors whose data this transaction depends on), successors (processors that depend on this one), squash (processors whose uncommitted writes were read), and directory successors (directories that hold a proxy copy of this processor's uncommitted lines). The load and store paths report dependency events, and other processors send commit and abort notices.

A commit request holds the instruction stream until every predecessor has left, then multicasts a commit notice to the successor processors and directories and clears the vectors. An abort fires at once, multicasts an abort notice to the same targets, and then waits, still stalled, until the predecessor set drains. An abort notice from a processor whose data was read cascades into a local abort. A processor that gains a new successor while it already has one aborts, because that pattern could close a dependency cycle. After a configurable number of such conflict aborts the tracker stops recording dependencies until a transaction commits.

Top module: `txn_dep_tracker`

## Requirements
- R1: A read-dependency event with source ID s sets bit s of the predecessor vector and of the squash vector (one bit per processor; directory-successor vector one bit per directory).
- R2: A store-dependency event sets in the predecessor vector every bit of the supplied sharer mask.
- R3: After a commit request, `stall_o` is high from the next cycle while the predecessor vector is non-empty. The commit takes place on the clock edge at which the predecessor vector, including that cycle's notice clears, is empty.
- R4: A commit drives, in the cycle after it takes place, `ntc_vld_o`=1, `ntc_abort_o`=0, `ntc_proc_o` equal to the successor vector and `ntc_dir_o` equal to the directory-successor vector, and all vectors are then empty.
- R5: An abort request inside a transaction produces, in the next cycle, an abort notice (`ntc_abort_o`=1) with the successor masks and `abort_cause_o`=1, with no waiting condition. It takes priority over a commit completing in the same cycle.
- R6: A received commit or abort notice from processor s clears bit s of the predecessor and successor vectors.
- R7: A received abort notice from a processor whose squash bit is set forces an abort with `abort_cause_o`=2. A commit notice from that processor clears its squash bit.
- R8: A successor-add event while any successor bit (processor or directory) is already set aborts with `abort_cause_o`=3, and the new successor is included in the notice mask.
- R9: Conflict aborts (causes 2 and 3) are counted, explicit aborts are not. When the count reaches FALLBACK_LIM, `fallback_o` goes high and dependency events are ignored. A commit clears the count.
- R10: After an abort with a non-empty predecessor vector, `stall_o` stays high until notices empty it. The tracker then returns to idle.
- R11: Outside a transaction, dependency events and abort/commit requests have no effect.
- R12: After reset, `stall_o`, `ntc_vld_o`, `fallback_o` and `abort_cause_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_begin_i | input | 1 | Start a transaction when idle |
| commit_req_i | input | 1 | Commit instruction |
| abort_req_i | input | 1 | Explicit abort or overflow |
| rd_dep_vld_i | input | 1 | Read of uncommitted data |
| rd_dep_src_i | input | PIDW | Writer of that data |
| wr_dep_vld_i | input | 1 | Store invalidated speculative sharers |
| wr_sharers_i | input | N_PROC | Sharer mask from the response |
| succ_add_vld_i | input | 1 | Another processor now depends on this one |
| succ_add_id_i | input | PIDW | That processor |
| dsucc_add_vld_i | input | 1 | A directory now proxies this processor's data |
| dsucc_add_id_i | input | DIDW | That directory |
| in_cmt_vld_i | input | 1 | Commit notice received |
| in_abt_vld_i | input | 1 | Abort notice received |
| in_src_i | input | PIDW | Sender of the notice |
| stall_o | output | 1 | Hold the instruction stream |
| ntc_vld_o | output | 1 | Outgoing notice valid |
| ntc_abort_o | output | 1 | Outgoing notice is an abort |
| ntc_proc_o | output | N_PROC | Processor targets |
| ntc_dir_o | output | N_DIR | Directory targets |
| abort_cause_o | output | 2 | 0 none, 1 explicit, 2 squash, 3 cycle |
| fallback_o | output | 1 | Dependency tracking disabled |

## Verification
Two events can meet in one cycle: the commit notice that removes the last predecessor, and the commit that it releases. The bench sweeps every predecessor mask, built both from sharer masks and from single read events. It retires predecessors one at a time and expects the outgoing commit notice exactly one cycle after the clearing notice, with successor bits dropped wherever the clearing sender was also a successor. A second collision, an abort request together with a commit request on an empty predecessor set, must yield an abort notice and not a commit.

// File: rtl/txdep_pkg.sv
package txdep_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_WAIT   = 2'd2,
      ST_DRAIN  = 2'd3
   } txn_state_e;

   typedef enum logic [1:0] {
      CAUSE_NONE     = 2'd0,
      CAUSE_EXPLICIT = 2'd1,
      CAUSE_SQUASH   = 2'd2,
      CAUSE_CYCLE    = 2'd3
   } abort_cause_e;
endpackage

// File: rtl/dep_vec.sv
module dep_vec #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic         flush_i,
   output logic [W-1:0] upd_o,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("dep_vec: W must be at least 1");
   end

   // clears win over sets arriving in the same cycle
   assign upd_o = (q_o | set_i) & ~clr_i;

   always_ff @(posedge clk) begin
      if (!rst_n)       q_o <= '0;
      else if (flush_i) q_o <= '0;
      else              q_o <= upd_o;
   end
endmodule

// File: rtl/conflict_ctr.sv
module conflict_ctr #(
   parameter int LIM = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic clr_i,
   output logic fallback_o
);
   localparam int CW = $clog2(LIM + 1);

   if (LIM < 1) begin : g_bad_lim
      $error("conflict_ctr: LIM must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr_i)              cnt_q <= '0;
      else if (inc_i && !fallback_o) cnt_q <= cnt_q + 1'b1;
   end

   assign fallback_o = (cnt_q == CW'(LIM));

   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIM));
   p_clr_exits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !fallback_o);
endmodule

// File: rtl/txn_dep_tracker.sv
module txn_dep_tracker
   import txdep_pkg::*;
#(
   parameter int N_PROC       = 4,
   parameter int N_DIR        = 2,
   parameter int MY_ID        = 0,
   parameter int FALLBACK_LIM = 2,
   parameter bit CYC_INCL_DIR = 1'b1,
   localparam int PIDW = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int DIDW = (N_DIR > 1) ? $clog2(N_DIR) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_begin_i,
   input  logic              commit_req_i,
   input  logic              abort_req_i,
   input  logic              rd_dep_vld_i,
   input  logic [PIDW-1:0]   rd_dep_src_i,
   input  logic              wr_dep_vld_i,
   input  logic [N_PROC-1:0] wr_sharers_i,
   input  logic              succ_add_vld_i,
   input  logic [PIDW-1:0]   succ_add_id_i,
   input  logic              dsucc_add_vld_i,
   input  logic [DIDW-1:0]   dsucc_add_id_i,
   input  logic              in_cmt_vld_i,
   input  logic              in_abt_vld_i,
   input  logic [PIDW-1:0]   in_src_i,
   output logic              stall_o,
   output logic              ntc_vld_o,
   output logic              ntc_abort_o,
   output logic [N_PROC-1:0] ntc_proc_o,
   output logic [N_DIR-1:0]  ntc_dir_o,
   output logic [1:0]        abort_cause_o,
   output logic              fallback_o
);
   if (N_PROC < 2) begin : g_bad_np
      $error("txn_dep_tracker: N_PROC must be at least 2");
   end
   if (N_DIR < 1) begin : g_bad_nd
      $error("txn_dep_tracker: N_DIR must be at least 1");
   end
   if (MY_ID < 0 || MY_ID >= N_PROC) begin : g_bad_id
      $error("txn_dep_tracker: MY_ID out of range");
   end

   txn_state_e   state_q, state_d;
   abort_cause_e cause_d;

   logic in_txn, track;
   logic [N_PROC-1:0] src_oh, rd_oh, succ_oh, pred_set, sq_set, succ_set;
   logic [N_DIR-1:0]  dsucc_oh, dsucc_set;
   logic [N_PROC-1:0] pred_q, pred_upd, succ_q, succ_upd, sq_q, sq_upd;
   logic [N_DIR-1:0]  dsucc_q, dsucc_upd;
   logic has_succ, cyc_hit, sq_hit, exp_hit, abort_now, want_commit, commit_now;
   logic fwd_flush;

   assign in_txn = (state_q == ST_ACTIVE) || (state_q == ST_WAIT);
   assign track  = in_txn && !fallback_o;

   // one-hot decode of the ID inputs
   always_comb begin
      src_oh   = '0;
      rd_oh    = '0;
      succ_oh  = '0;
      dsucc_oh = '0;
      if (in_cmt_vld_i || in_abt_vld_i) src_oh[in_src_i]       = 1'b1;
      if (rd_dep_vld_i)                 rd_oh[rd_dep_src_i]    = 1'b1;
      if (succ_add_vld_i)               succ_oh[succ_add_id_i] = 1'b1;
      if (dsucc_add_vld_i)              dsucc_oh[dsucc_add_id_i] = 1'b1;
   end

   assign pred_set  = track ? (rd_oh | (wr_dep_vld_i ? wr_sharers_i : '0)) : '0;
   assign sq_set    = track ? rd_oh : '0;
   assign succ_set  = track ? succ_oh : '0;
   assign dsucc_set = track ? dsucc_oh : '0;

   // variant: whether directory successors count as outbound edges
   if (CYC_INCL_DIR) begin : g_cyc_dir
      assign has_succ = (|succ_q) || (|dsucc_q);
   end else begin : g_cyc_proc
      assign has_succ = |succ_q;
   end

   assign cyc_hit   = track && succ_add_vld_i && has_succ;
   assign sq_hit    = in_txn && in_abt_vld_i && |(sq_q & src_oh);
   assign exp_hit   = in_txn && abort_req_i;
   assign abort_now = cyc_hit || sq_hit || exp_hit;

   assign want_commit = (state_q == ST_WAIT) || ((state_q == ST_ACTIVE) && commit_req_i);
   assign commit_now  = want_commit && !abort_now && (pred_upd == '0);
   assign fwd_flush   = commit_now || abort_now;

   dep_vec #(.W(N_PROC)) u_pred (
      .clk(clk), .rst_n(rst_n), .set_i(pred_set), .clr_i(src_oh),
      .flush_i(commit_now), .upd_o(pred_upd), .q_o(pred_q));

   dep_vec #(.W(N_PROC)) u_succ (
      .clk(clk), .rst_n(rst_n), .set_i(succ_set), .clr_i(src_oh),
      .flush_i(fwd_flush), .upd_o(succ_upd), .q_o(succ_q));

   dep_vec #(.W(N_PROC)) u_squash (
      .clk(clk), .rst_n(rst_n), .set_i(sq_set), .clr_i(src_oh),
      .flush_i(fwd_flush), .upd_o(sq_upd), .q_o(sq_q));

   dep_vec #(.W(N_DIR)) u_dsucc (
      .clk(clk), .rst_n(rst_n), .set_i(dsucc_set), .clr_i('0),
      .flush_i(fwd_flush), .upd_o(dsucc_upd), .q_o(dsucc_q));

   conflict_ctr #(.LIM(FALLBACK_LIM)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc_i(cyc_hit || sq_hit),
      .clr_i(commit_now), .fallback_o(fallback_o));

   always_comb begin
      if (cyc_hit)      cause_d = CAUSE_CYCLE;
      else if (sq_hit)  cause_d = CAUSE_SQUASH;
      else if (exp_hit) cause_d = CAUSE_EXPLICIT;
      else              cause_d = CAUSE_NONE;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (txn_begin_i) state_d = ST_ACTIVE;
         ST_ACTIVE, ST_WAIT: begin
            if (abort_now)         state_d = (pred_upd != '0) ? ST_DRAIN : ST_IDLE;
            else if (commit_now)   state_d = ST_IDLE;
            else if (want_commit)  state_d = ST_WAIT;
         end
         ST_DRAIN:  if (pred_upd == '0) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         ntc_vld_o     <= 1'b0;
         ntc_abort_o   <= 1'b0;
         ntc_proc_o    <= '0;
         ntc_dir_o     <= '0;
         abort_cause_o <= CAUSE_NONE;
      end else begin
         state_q       <= state_d;
         ntc_vld_o     <= fwd_flush;
         ntc_abort_o   <= abort_now;
         ntc_proc_o    <= fwd_flush ? succ_upd : '0;
         ntc_dir_o     <= fwd_flush ? dsucc_upd : '0;
         abort_cause_o <= cause_d;
      end
   end

   assign stall_o = (state_q == ST_WAIT) || (state_q == ST_DRAIN);

   p_commit_from_txn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ntc_vld_o && !ntc_abort_o) |-> ($past(state_q) == ST_ACTIVE || $past(state_q) == ST_WAIT));
   p_commit_leaves_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ntc_vld_o && !ntc_abort_o) |-> (pred_q == '0 && succ_q == '0 && dsucc_q == '0));
   p_wait_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> (stall_o && pred_q != '0));
   p_abort_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ntc_abort_o |-> (succ_q == '0 && sq_q == '0 && abort_cause_o != CAUSE_NONE));
   p_drain_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRAIN) |-> (pred_q != '0));
   p_fallback_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fallback_o && sq_q == '0) |=> (sq_q == '0));
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |=> !ntc_vld_o);
endmodule

// File: tb/tb_txn_dep_tracker.sv
module tb_txn_dep_tracker;
   localparam int NP = 4;
   localparam int ND = 2;
   localparam int LIM = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_begin_i = 0, commit_req_i = 0, abort_req_i = 0;
   logic rd_dep_vld_i = 0, wr_dep_vld_i = 0, succ_add_vld_i = 0, dsucc_add_vld_i = 0;
   logic [1:0] rd_dep_src_i = 0, succ_add_id_i = 0, in_src_i = 0;
   logic [0:0] dsucc_add_id_i = 0;
   logic [NP-1:0] wr_sharers_i = 0;
   logic in_cmt_vld_i = 0, in_abt_vld_i = 0;
   logic stall_o, ntc_vld_o, ntc_abort_o, fallback_o;
   logic [NP-1:0] ntc_proc_o;
   logic [ND-1:0] ntc_dir_o;
   logic [1:0] abort_cause_o;

   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   txn_dep_tracker #(.N_PROC(NP), .N_DIR(ND), .MY_ID(0), .FALLBACK_LIM(LIM)) dut (
      .clk(clk), .rst_n(rst_n), .txn_begin_i(txn_begin_i), .commit_req_i(commit_req_i),
      .abort_req_i(abort_req_i), .rd_dep_vld_i(rd_dep_vld_i), .rd_dep_src_i(rd_dep_src_i),
      .wr_dep_vld_i(wr_dep_vld_i), .wr_sharers_i(wr_sharers_i),
      .succ_add_vld_i(succ_add_vld_i), .succ_add_id_i(succ_add_id_i),
      .dsucc_add_vld_i(dsucc_add_vld_i), .dsucc_add_id_i(dsucc_add_id_i),
      .in_cmt_vld_i(in_cmt_vld_i), .in_abt_vld_i(in_abt_vld_i), .in_src_i(in_src_i),
      .stall_o(stall_o), .ntc_vld_o(ntc_vld_o), .ntc_abort_o(ntc_abort_o),
      .ntc_proc_o(ntc_proc_o), .ntc_dir_o(ntc_dir_o), .abort_cause_o(abort_cause_o),
      .fallback_o(fallback_o));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      txn_begin_i = 0; commit_req_i = 0; abort_req_i = 0;
      rd_dep_vld_i = 0; wr_dep_vld_i = 0; succ_add_vld_i = 0; dsucc_add_vld_i = 0;
      in_cmt_vld_i = 0; in_abt_vld_i = 0; wr_sharers_i = 0;
   endtask

   task automatic notice(input bit is_abt, input int src);
      in_cmt_vld_i = !is_abt; in_abt_vld_i = is_abt; in_src_i = 2'(src); tick();
   endtask

   task automatic begin_txn();
      txn_begin_i = 1; tick();
   endtask

   // commit an empty transaction: clears conflict count
   task automatic clean_commit(input string req);
      begin_txn(); commit_req_i = 1; tick();
      chk({req, " clean commit"}, ntc_vld_o && !ntc_abort_o, 1);
      chk({req, " fallback cleared"}, fallback_o, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick();
      // R12 reset state
      chk("R12 stall", stall_o, 0);
      chk("R12 ntc_vld", ntc_vld_o, 0);
      chk("R12 fallback", fallback_o, 0);
      chk("R12 cause", abort_cause_o, 0);

      // Sweep: R1 R2 R3 R4 R6 over all predecessor masks
      for (int m = 0; m < 8; m++) begin
         for (int md = 0; md < 2; md++) begin
            int pm, es, ed, rem;
            pm = m << 1; es = 0; ed = 0;
            begin_txn();
            if (md == 0) begin
               wr_dep_vld_i = 1; wr_sharers_i = 4'(pm); tick();      // R2
            end else begin
               for (int i = 1; i < NP; i++) if (pm[i]) begin
                  rd_dep_vld_i = 1; rd_dep_src_i = 2'(i); tick();  // R1
               end
            end
            if (m[2]) begin succ_add_vld_i = 1; succ_add_id_i = 2'd2; tick(); es = 4; end
            if (m[0]) begin dsucc_add_vld_i = 1; dsucc_add_id_i = 1'b0; tick(); ed |= 1; end
            if (m[1]) begin dsucc_add_vld_i = 1; dsucc_add_id_i = 1'b1; tick(); ed |= 2; end
            commit_req_i = 1; tick();
            if (pm == 0) begin
               chk("R4 immediate commit vld", ntc_vld_o && !ntc_abort_o, 1);
               chk("R4 proc mask", ntc_proc_o, es);
               chk("R4 dir mask", ntc_dir_o, ed);
            end else begin
               chk(md ? "R1 pred stall" : "R2 pred stall", stall_o, 1);
               chk("R3 no early commit", ntc_vld_o, 0);
               rem = pm;
               for (int i = 1; i < NP; i++) if (pm[i]) begin
                  notice(0, i);
                  rem &= ~(1 << i); es &= ~(1 << i);   // R6 clears sender
                  if (rem == 0) begin
                     chk("R3 commit same-cycle release", ntc_vld_o && !ntc_abort_o, 1);
                     chk("R6 proc mask after clear", ntc_proc_o, es);
                     chk("R4 dir mask", ntc_dir_o, ed);
                     chk("R3 stall released", stall_o, 0);
                  end else begin
                     chk("R3 still stalled", stall_o, 1);
                     chk("R3 no commit yet", ntc_vld_o, 0);
                  end
               end
            end
            tick();
            chk("R4 single notice", ntc_vld_o, 0);
         end
      end

      // R7 squash cascade
      for (int s = 1; s < NP; s++) begin
         for (int x = 1; x < NP; x++) begin
            begin_txn();
            rd_dep_vld_i = 1; rd_dep_src_i = 2'(s); tick();
            notice(1, x);
            if (x == s) begin
               chk("R7 squash abort", ntc_vld_o && ntc_abort_o, 1);
               chk("R7 cause", abort_cause_o, 2);
               chk("R7 no drain", stall_o, 0);
               tick();
               clean_commit("R9");
            end else begin
               chk("R7 unrelated abort ignored", ntc_vld_o, 0);
               abort_req_i = 1; tick();
               chk("R5 explicit abort", ntc_vld_o && ntc_abort_o, 1);
               chk("R5 cause", abort_cause_o, 1);
               chk("R10 drain stall", stall_o, 1);
               tick();
               chk("R10 still draining", stall_o, 1);
               notice(0, s);
               chk("R10 drained", stall_o, 0);
            end
         end
      end

      // R7 commit notice from squash source clears squash bit
      begin_txn();
      rd_dep_vld_i = 1; rd_dep_src_i = 2'd3; tick();
      wr_dep_vld_i = 1; wr_sharers_i = 4'b0100; tick();
      notice(0, 3);
      notice(1, 3);
      chk("R7 cleared squash no abort", ntc_vld_o, 0);
      abort_req_i = 1; tick(); tick();
      notice(0, 2);
      chk("R10 idle after drain", stall_o, 0);

      // R8 cycle detection
      begin_txn();
      succ_add_vld_i = 1; succ_add_id_i = 2'd1; tick();
      chk("R8 first successor no abort", ntc_vld_o, 0);
      succ_add_vld_i = 1; succ_add_id_i = 2'd2; tick();
      chk("R8 cycle abort", ntc_vld_o && ntc_abort_o, 1);
      chk("R8 cause", abort_cause_o, 3);
      chk("R8 mask includes new", ntc_proc_o, 6);
      // count is 1; explicit abort must not count (R9)
      begin_txn(); abort_req_i = 1; tick();
      chk("R9 explicit not counted", fallback_o, 0);
      begin_txn();
      dsucc_add_vld_i = 1; dsucc_add_id_i = 1'b1; tick();
      succ_add_vld_i = 1; succ_add_id_i = 2'd3; tick();
      chk("R8 dir successor counts", abort_cause_o, 3);
      chk("R8 dir mask", ntc_dir_o, 2);
      chk("R9 fallback entered", fallback_o, 1);
      // R9 fallback ignores dependencies
      begin_txn();
      rd_dep_vld_i = 1; rd_dep_src_i = 2'd1; tick();
      succ_add_vld_i = 1; succ_add_id_i = 2'd2; tick();
      commit_req_i = 1; tick();
      chk("R9 untracked commit", ntc_vld_o && !ntc_abort_o, 1);
      chk("R9 no successors", ntc_proc_o, 0);
      chk("R9 commit resets count", fallback_o, 0);

      // R11 idle: events ignored
      tick();
      abort_req_i = 1; rd_dep_vld_i = 1; rd_dep_src_i = 2'd1; commit_req_i = 1; tick();
      chk("R11 idle no notice", ntc_vld_o, 0);
      chk("R11 idle no stall", stall_o, 0);
      begin_txn(); commit_req_i = 1; tick();
      chk("R11 idle dep not kept", ntc_vld_o && !ntc_abort_o, 1);

      // R5 abort beats same-cycle commit
      begin_txn();
      commit_req_i = 1; abort_req_i = 1; tick();
      chk("R5 abort priority", ntc_abort_o, 1);
      chk("R5 abort priority cause", abort_cause_o, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule